// File: doc/BRIEF.md
# Compression Header Policy and Error Registers

This block sits in front of an IQ compressor (transmit side) and an IQ decompressor (receive side). It decides which compression header each packet uses and whether that header is acceptable. A small register file sets the header source. In static mode, a header held in a register replaces every incoming one. In dynamic mode, the header that arrives with the packet is used. Either way, the chosen header is checked against the compression methods and IQ widths that the block was built to support.

The header byte has two fields. Bits [7:4] give the IQ width, where code 0 means 16 bits. Bits [3:0] give the method code. The two directions handle a bad header in different ways. Transmit repairs a bad width by forcing it to 16 bits, and it asks for the packet to be dropped when the method is bad. Receive asks for a drop when the width is bad, and it replaces a bad method with a default chosen from the enabled methods. Each fault sets a sticky bit in that direction's error register. Software clears these bits by writing ones to them. One interrupt line reports that any bit is set.

For each packet the block takes one strobe with a header, and one cycle later it returns the corrected header, a valid pulse and a drop flag. The compression datapath itself lies outside this block.

Top module: `hdr_policy_top`

## Requirements
- R1: After a synchronous reset, the mode register and both error registers hold zero, and the valid, drop and interrupt outputs are low.
- R2: A read at offset 0 returns the mode register in bits [8:0]. Bit 8 selects dynamic mode and bits [7:0] hold the static header. A read at offset 1 returns the transmit error bits in bits [1:0]. A read at offset 2 returns the receive error bits in bits [1:0]. Every higher bit, and every other offset, reads zero. Read data appears the cycle after the read request and holds until the next read.
- R3: In static mode (bit 8 = 0), the static header replaces the incoming header. The replacement is checked and corrected by the same rules as an incoming header.
- R4: Method code 0000 (no compression) is always accepted. Code 0001 (block floating point) is accepted only when BFP_EN is set. Code 0011 (mu-law) is accepted only when MULAW_EN is set. Every other code is invalid.
- R5: Width code 0 stands for 16 bits. With EXT_WIDTH_EN set, codes 0 and 8 to 15 are accepted. Otherwise only codes 0, 9, 12 and 14 are accepted.
- R6: On transmit, a bad width sets transmit error bit 1 and forces the output width field to 0000. The method field passes through unchanged, and a bad width alone does not drop the packet.
- R7: On transmit, a bad method sets transmit error bit 0 and raises the drop output.
- R8: On receive, a bad width sets receive error bit 1 and raises the drop output. The header passes through with its width unchanged.
- R9: On receive, a bad method sets receive error bit 0 and is replaced by a default. The default is 0001 when BFP_EN is set, otherwise 0011 when MULAW_EN is set, otherwise 0000. A bad method alone does not drop the packet.
- R10: Writing a one to an error bit clears it, and writing a zero leaves it unchanged. When a fault sets a bit in the same cycle that a write clears it, the bit stays set.
- R11: The interrupt output is high exactly when at least one of the four error bits is set. It changes in the same cycle as the bits.
- R12: The corrected header, valid and drop appear in the cycle after the strobe. Valid lasts one cycle, and drop is never high without valid. A mode write affects only strobes in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write request |
| reg_rd_en | input | 1 | Register read request |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| tx_hdr_stb | input | 1 | Transmit header strobe, one per packet |
| tx_hdr_in | input | 8 | Transmit packet header |
| tx_hdr_out | output | 8 | Corrected transmit header |
| tx_hdr_vld | output | 1 | Transmit result valid |
| tx_drop | output | 1 | Drop request for the transmit packet |
| rx_hdr_stb | input | 1 | Receive header strobe, one per packet |
| rx_hdr_in | input | 8 | Receive packet header |
| rx_hdr_out | output | 8 | Corrected receive header |
| rx_hdr_vld | output | 1 | Receive result valid |
| rx_drop | output | 1 | Drop request for the receive packet |
| irq | output | 1 | High while any error bit is set |

## Verification
Two instances are built with different settings. One supports both methods but only the short width list. The other supports mu-law only and accepts the extended widths. On the same stimulus, the two instances disagree on block floating point acceptance, on widths such as 10, and on which default method receive substitutes. Every one of the 256 header values is sent down both directions in dynamic mode, so every combination of good and bad method and width is seen. Directed packets then single out each fault alone and both together. Static mode is checked with the incoming header set to a value that differs from the register, which shows that the register header wins. A mode write in the same cycle as a strobe shows when the new mode takes effect. Writes that clear error bits are tried with zero data, one bit at a time, and in the same cycle as a new fault, which shows that clearing and setting stay separate.

// File: rtl/hdrpol_pkg.sv
package hdrpol_pkg;
  localparam int HDR_W     = 8;
  localparam int FIELD_W   = 4;
  localparam int MODE_W    = HDR_W + 1;
  localparam int DYN_BIT   = HDR_W;
  localparam int ERR_W     = 2;
  localparam int ERR_METH  = 0;
  localparam int ERR_WIDTH = 1;
  localparam int NUM_DIR   = 2;
  localparam int DIR_TX    = 0;
  localparam int DIR_RX    = 1;
  localparam int OFS_MODE  = 0;
  localparam int OFS_TXERR = 1;
  localparam int OFS_RXERR = 2;

  typedef enum logic [FIELD_W-1:0] {
    METH_NONE  = 4'b0000,
    METH_BFP   = 4'b0001,
    METH_MULAW = 4'b0011
  } meth_e;

  typedef struct packed {
    logic [FIELD_W-1:0] width;
    logic [FIELD_W-1:0] meth;
  } cmp_hdr_t;

  function automatic logic meth_legal(input logic [FIELD_W-1:0] m,
                                      input bit bfp_en, input bit mu_en);
    case (m)
      METH_NONE:  meth_legal = 1'b1;
      METH_BFP:   meth_legal = bfp_en;
      METH_MULAW: meth_legal = mu_en;
      default:    meth_legal = 1'b0;
    endcase
  endfunction

  function automatic logic width_legal(input logic [FIELD_W-1:0] w, input bit ext_en);
    if (ext_en)
      width_legal = (w == 4'd0) || (w >= 4'd8);
    else
      width_legal = (w == 4'd0) || (w == 4'd9) || (w == 4'd12) || (w == 4'd14);
  endfunction

  function automatic logic [FIELD_W-1:0] fallback_meth(input bit bfp_en, input bit mu_en);
    if (bfp_en)     fallback_meth = METH_BFP;
    else if (mu_en) fallback_meth = METH_MULAW;
    else            fallback_meth = METH_NONE;
  endfunction
endpackage

// File: rtl/hdr_check.sv
module hdr_check
  import hdrpol_pkg::*;
#(
  parameter bit IS_RX        = 1'b0,
  parameter bit BFP_EN       = 1'b1,
  parameter bit MULAW_EN     = 1'b1,
  parameter bit EXT_WIDTH_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic             dyn_i,
  input  logic [HDR_W-1:0] static_i,
  output logic [HDR_W-1:0] hdr_o,
  output logic             vld_o,
  output logic             drop_o,
  output logic             bad_meth_o,
  output logic             bad_width_o
);
  cmp_hdr_t sel_hdr, fix_hdr, out_q;
  logic     meth_ok, width_ok, drop_d;

  assign sel_hdr  = dyn_i ? cmp_hdr_t'(hdr_i) : cmp_hdr_t'(static_i);
  assign meth_ok  = meth_legal(sel_hdr.meth, BFP_EN, MULAW_EN);
  assign width_ok = width_legal(sel_hdr.width, EXT_WIDTH_EN);

  assign bad_meth_o  = stb_i && !meth_ok;
  assign bad_width_o = stb_i && !width_ok;

  generate
    if (IS_RX) begin : g_rx
      always_comb begin
        fix_hdr.width = sel_hdr.width;
        fix_hdr.meth  = meth_ok ? sel_hdr.meth : fallback_meth(BFP_EN, MULAW_EN);
        drop_d        = !width_ok;
      end
    end else begin : g_tx
      always_comb begin
        fix_hdr.width = width_ok ? sel_hdr.width : '0;
        fix_hdr.meth  = sel_hdr.meth;
        drop_d        = !meth_ok;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      vld_o  <= 1'b0;
      drop_o <= 1'b0;
    end else begin
      vld_o  <= stb_i;
      drop_o <= stb_i && drop_d;
      if (stb_i) out_q <= fix_hdr;
    end
  end

  assign hdr_o = out_q;

  AST_VLD_FOLLOWS_STB: assert property (@(posedge clk) disable iff (rst) stb_i |=> vld_o); // R12
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) !stb_i |=> !vld_o); // R12
  AST_DROP_WITH_VLD: assert property (@(posedge clk) disable iff (rst) drop_o |-> vld_o); // R12

  generate
    if (IS_RX) begin : g_rx_chk
      AST_RX_METH_REPAIRED: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> meth_legal(out_q.meth, BFP_EN, MULAW_EN) || !(BFP_EN || MULAW_EN)); // R9
      AST_RX_DROP_BAD_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !width_legal(out_q.width, EXT_WIDTH_EN)) |-> drop_o); // R8
    end else begin : g_tx_chk
      AST_TX_WIDTH_REPAIRED: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> width_legal(out_q.width, EXT_WIDTH_EN)); // R6
      AST_TX_DROP_BAD_METH: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !meth_legal(out_q.meth, BFP_EN, MULAW_EN)) |-> drop_o); // R7
    end
  endgenerate
endmodule

// File: rtl/hdr_regs.sv
module hdr_regs
  import hdrpol_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [ERR_W-1:0]  set_i [NUM_DIR],
  output logic              dyn_o,
  output logic [HDR_W-1:0]  static_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - MODE_W;

  logic [MODE_W-1:0] mode_q;
  logic [ERR_W-1:0]  err_q [NUM_DIR];
  logic [ERR_W-1:0]  err_d [NUM_DIR];
  logic              wr_err [NUM_DIR];
  logic              wr_mode;
  logic              any_err_d;
  logic [PAD_W-1:0]  unused_wdata_hi;

  assign unused_wdata_hi = wdata[DATA_W-1:MODE_W];
  assign wr_mode = wr_en && (addr == ADDR_W'(OFS_MODE));

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_err
      localparam int OFS = (d == DIR_TX) ? OFS_TXERR : OFS_RXERR;
      assign wr_err[d] = wr_en && (addr == ADDR_W'(OFS));
      always_comb begin
        err_d[d] = wr_err[d] ? (err_q[d] & ~wdata[ERR_W-1:0]) : err_q[d];
        err_d[d] = err_d[d] | set_i[d];
      end
      always_ff @(posedge clk) begin
        if (rst) err_q[d] <= '0;
        else     err_q[d] <= err_d[d];
      end
      for (genvar b = 0; b < ERR_W; b++) begin : g_bit
        AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
          set_i[d][b] |=> err_q[d][b]); // R10
        AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
          (err_q[d][b] && !(wr_err[d] && wdata[b])) |=> err_q[d][b]); // R10
        AST_ERR_W1C: assert property (@(posedge clk) disable iff (rst)
          (!set_i[d][b] && wr_err[d] && wdata[b]) |=> !err_q[d][b]); // R10
      end
    end
  endgenerate

  assign any_err_d = (|err_d[DIR_TX]) || (|err_d[DIR_RX]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      rdata  <= '0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= any_err_d;
      if (wr_mode) mode_q <= wdata[MODE_W-1:0];
      if (rd_en) begin
        case (addr)
          ADDR_W'(OFS_MODE):  rdata <= DATA_W'(mode_q);
          ADDR_W'(OFS_TXERR): rdata <= DATA_W'(err_q[DIR_TX]);
          ADDR_W'(OFS_RXERR): rdata <= DATA_W'(err_q[DIR_RX]);
          default:            rdata <= '0;
        endcase
      end
    end
  end

  assign dyn_o    = mode_q[DYN_BIT];
  assign static_o = mode_q[HDR_W-1:0];

  AST_IRQ_TRACKS_ERR: assert property (@(posedge clk) disable iff (rst)
    irq_o == ((|err_q[DIR_TX]) || (|err_q[DIR_RX]))); // R11
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:MODE_W] == '0); // R2
endmodule

// File: rtl/hdr_policy_top.sv
module hdr_policy_top
  import hdrpol_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 32,
  parameter bit BFP_EN       = 1'b1,
  parameter bit MULAW_EN     = 1'b1,
  parameter bit EXT_WIDTH_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_hdr_stb,
  input  logic [7:0]        tx_hdr_in,
  output logic [7:0]        tx_hdr_out,
  output logic              tx_hdr_vld,
  output logic              tx_drop,
  input  logic              rx_hdr_stb,
  input  logic [7:0]        rx_hdr_in,
  output logic [7:0]        rx_hdr_out,
  output logic              rx_hdr_vld,
  output logic              rx_drop,
  output logic              irq
);
  logic             stb   [NUM_DIR];
  logic [HDR_W-1:0] h_in  [NUM_DIR];
  logic [HDR_W-1:0] h_out [NUM_DIR];
  logic             vld   [NUM_DIR];
  logic             drop  [NUM_DIR];
  logic [ERR_W-1:0] set   [NUM_DIR];
  logic             dyn_mode;
  logic [HDR_W-1:0] static_hdr;

  assign stb[DIR_TX]  = tx_hdr_stb;
  assign stb[DIR_RX]  = rx_hdr_stb;
  assign h_in[DIR_TX] = tx_hdr_in;
  assign h_in[DIR_RX] = rx_hdr_in;

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      logic bad_m, bad_w;
      hdr_check #(
        .IS_RX       (d == DIR_RX),
        .BFP_EN      (BFP_EN),
        .MULAW_EN    (MULAW_EN),
        .EXT_WIDTH_EN(EXT_WIDTH_EN)
      ) u_check (
        .clk        (clk),
        .rst        (rst),
        .stb_i      (stb[d]),
        .hdr_i      (h_in[d]),
        .dyn_i      (dyn_mode),
        .static_i   (static_hdr),
        .hdr_o      (h_out[d]),
        .vld_o      (vld[d]),
        .drop_o     (drop[d]),
        .bad_meth_o (bad_m),
        .bad_width_o(bad_w)
      );
      always_comb begin
        set[d]            = '0;
        set[d][ERR_METH]  = bad_m;
        set[d][ERR_WIDTH] = bad_w;
      end
    end
  endgenerate

  hdr_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .rd_en   (reg_rd_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .set_i   (set),
    .dyn_o   (dyn_mode),
    .static_o(static_hdr),
    .irq_o   (irq)
  );

  assign tx_hdr_out = h_out[DIR_TX];
  assign tx_hdr_vld = vld[DIR_TX];
  assign tx_drop    = drop[DIR_TX];
  assign rx_hdr_out = h_out[DIR_RX];
  assign rx_hdr_vld = vld[DIR_RX];
  assign rx_drop    = drop[DIR_RX];

  AST_TX_VLD_TIMING: assert property (@(posedge clk) disable iff (rst) tx_hdr_stb |=> tx_hdr_vld); // R12
  AST_RX_VLD_TIMING: assert property (@(posedge clk) disable iff (rst) rx_hdr_stb |=> rx_hdr_vld); // R12
endmodule

// File: tb/tb_hdr_policy_top.sv
`timescale 1ns/1ps
module tb_hdr_policy_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 0, reg_rd_en = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic        tx_hdr_stb = 0, rx_hdr_stb = 0;
  logic [7:0]  tx_hdr_in = 0, rx_hdr_in = 0;

  logic [31:0] rdata [2];
  logic [7:0]  txo [2], rxo [2];
  logic        txv [2], txd [2], rxv [2], rxd [2], irqo [2];

  int checks = 0, errors = 0;
  bit started = 0, done = 0;

  always #2 clk = ~clk;

  hdr_policy_top dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata[0]),
    .tx_hdr_stb(tx_hdr_stb), .tx_hdr_in(tx_hdr_in), .tx_hdr_out(txo[0]),
    .tx_hdr_vld(txv[0]), .tx_drop(txd[0]), .rx_hdr_stb(rx_hdr_stb),
    .rx_hdr_in(rx_hdr_in), .rx_hdr_out(rxo[0]), .rx_hdr_vld(rxv[0]),
    .rx_drop(rxd[0]), .irq(irqo[0]));

  hdr_policy_top #(.BFP_EN(1'b0), .MULAW_EN(1'b1), .EXT_WIDTH_EN(1'b1)) dut_b (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata[1]),
    .tx_hdr_stb(tx_hdr_stb), .tx_hdr_in(tx_hdr_in), .tx_hdr_out(txo[1]),
    .tx_hdr_vld(txv[1]), .tx_drop(txd[1]), .rx_hdr_stb(rx_hdr_stb),
    .rx_hdr_in(rx_hdr_in), .rx_hdr_out(rxo[1]), .rx_hdr_vld(rxv[1]),
    .rx_drop(rxd[1]), .irq(irqo[1]));

  // configuration of each instance: bfp enable, mu-law enable, extended widths
  int cf_bfp [2] = '{1, 0};
  int cf_mu  [2] = '{1, 1};
  int cf_ext [2] = '{0, 1};

  // behavioural expectations
  int m_mode [2], m_txe [2], m_rxe [2], m_rd [2];
  int m_txo [2], m_rxo [2], m_txv [2], m_txd [2], m_rxv [2], m_rxd [2], m_irq [2];

  function automatic int ok_meth(int m, int k);
    return (m == 0) || (m == 1 && cf_bfp[k] != 0) || (m == 3 && cf_mu[k] != 0);
  endfunction

  function automatic int ok_width(int w, int k);
    if (cf_ext[k] != 0) return (w == 0) || (w >= 8);
    return w inside {0, 9, 12, 14};
  endfunction

  function automatic int dflt(int k);
    if (cf_bfp[k] != 0) return 1;
    if (cf_mu[k] != 0) return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_mode[k] = 0; m_txe[k] = 0; m_rxe[k] = 0; m_rd[k] = 0;
        m_txo[k] = 0; m_rxo[k] = 0; m_txv[k] = 0; m_txd[k] = 0;
        m_rxv[k] = 0; m_rxd[k] = 0; m_irq[k] = 0;
      end else begin
        int h, w, m, st, sr;
        st = 0; sr = 0;
        if (reg_rd_en) begin
          if (reg_addr == 0)      m_rd[k] = m_mode[k];
          else if (reg_addr == 1) m_rd[k] = m_txe[k];
          else if (reg_addr == 2) m_rd[k] = m_rxe[k];
          else                    m_rd[k] = 0;
        end
        m_txv[k] = tx_hdr_stb; m_txd[k] = 0;
        if (tx_hdr_stb) begin
          h = (m_mode[k] >= 256) ? int'(tx_hdr_in) : (m_mode[k] % 256);
          w = h / 16; m = h % 16;
          if (!ok_width(w, k)) begin st += 2; w = 0; end
          if (!ok_meth(m, k)) begin st += 1; m_txd[k] = 1; end
          m_txo[k] = w * 16 + m;
        end
        m_rxv[k] = rx_hdr_stb; m_rxd[k] = 0;
        if (rx_hdr_stb) begin
          h = (m_mode[k] >= 256) ? int'(rx_hdr_in) : (m_mode[k] % 256);
          w = h / 16; m = h % 16;
          if (!ok_width(w, k)) begin sr += 2; m_rxd[k] = 1; end
          if (!ok_meth(m, k)) begin sr += 1; m = dflt(k); end
          m_rxo[k] = w * 16 + m;
        end
        if (reg_wr_en && reg_addr == 1) m_txe[k] = m_txe[k] & ~int'(reg_wdata[1:0]);
        if (reg_wr_en && reg_addr == 2) m_rxe[k] = m_rxe[k] & ~int'(reg_wdata[1:0]);
        m_txe[k] = m_txe[k] | st;
        m_rxe[k] = m_rxe[k] | sr;
        if (reg_wr_en && reg_addr == 0) m_mode[k] = int'(reg_wdata[8:0]);
        m_irq[k] = (m_txe[k] != 0 || m_rxe[k] != 0);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      for (int k = 0; k < 2; k++) begin
        chk($sformatf("R2 model rdata inst%0d", k), int'(rdata[k]), m_rd[k]);
        chk($sformatf("R12 model tx vld inst%0d", k), int'(txv[k]), m_txv[k]);
        chk($sformatf("R12 model rx vld inst%0d", k), int'(rxv[k]), m_rxv[k]);
        chk($sformatf("R3/R4/R5/R6 model tx hdr inst%0d", k), int'(txo[k]), m_txo[k]);
        chk($sformatf("R7 model tx drop inst%0d", k), int'(txd[k]), m_txd[k]);
        chk($sformatf("R3/R4/R5/R9 model rx hdr inst%0d", k), int'(rxo[k]), m_rxo[k]);
        chk($sformatf("R8 model rx drop inst%0d", k), int'(rxd[k]), m_rxd[k]);
        chk($sformatf("R11 model irq inst%0d", k), int'(irqo[k]), m_irq[k]);
      end
    end
  end

  task automatic drv(input bit we, input bit re, input int a, input int wd,
                     input bit ts, input int th, input bit rs, input int rh);
    @(negedge clk);
    reg_wr_en = we; reg_rd_en = re; reg_addr = 4'(a); reg_wdata = 32'(wd);
    tx_hdr_stb = ts; tx_hdr_in = 8'(th); rx_hdr_stb = rs; rx_hdr_in = 8'(rh);
  endtask

  task automatic idle();
    drv(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int a, input int wd);
    drv(1, 0, a, wd, 0, 0, 0, 0);
    idle();
  endtask

  task automatic rd(input int a, output int d0, output int d1);
    drv(0, 1, a, 0, 0, 0, 0, 0);
    idle();
    d0 = int'(rdata[0]); d1 = int'(rdata[1]);
  endtask

  task automatic tx(input int h);
    drv(0, 0, 0, 0, 1, h, 0, 0);
    idle();
  endtask

  task automatic rx(input int h);
    drv(0, 0, 0, 0, 0, 0, 1, h);
    idle();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a0, a1;
    repeat (3) @(negedge clk);
    rst = 0;
    started = 1;
    idle();
    chk("R1 tx vld after reset", int'(txv[0]), 0);
    chk("R1 irq after reset", int'(irqo[0]), 0);
    rd(0, a0, a1); chk("R1 mode reset", a0, 0);
    rd(1, a0, a1); chk("R1 tx err reset", a0, 0);
    rd(2, a0, a1); chk("R1 rx err reset", a0, 0);

    wr(0, 32'hFFFF_FFFF);
    rd(0, a0, a1); chk("R2 mode upper bits zero", a0, 32'h1FF);
    rd(3, a0, a1); chk("R2 offset 3 reads zero", a0, 0);
    rd(15, a0, a1); chk("R2 offset 15 reads zero", a0, 0);

    wr(0, 32'h100);
    tx(8'h51);
    chk("R6 tx width forced", int'(txo[0]), 8'h01);
    chk("R6 tx no drop on width", int'(txd[0]), 0);
    rd(1, a0, a1); chk("R6 tx err bit1", a0, 2);
    wr(1, 2);
    rd(1, a0, a1); chk("R10 tx err cleared", a0, 0);

    tx(8'h92);
    chk("R7 tx drop on bad method", int'(txd[0]), 1);
    chk("R11 irq on tx error", int'(irqo[0]), 1);
    rd(1, a0, a1); chk("R7 tx err bit0", a0, 1);
    tx(8'h91);
    chk("R4 bfp disabled drops inst_b", int'(txd[1]), 1);
    chk("R4 bfp enabled passes", int'(txd[0]), 0);

    rx(8'hA3);
    chk("R8 rx drop on width 10", int'(rxd[0]), 1);
    chk("R5 width 10 accepted extended", int'(rxd[1]), 0);
    rx(8'hC7);
    chk("R9 rx default bfp", int'(rxo[0]), 8'hC1);
    chk("R9 rx default mulaw", int'(rxo[1]), 8'hC3);
    chk("R9 rx no drop on method", int'(rxd[0]), 0);
    rd(2, a0, a1); chk("R8 R9 rx err bits", a0, 3);

    wr(2, 0);
    rd(2, a0, a1); chk("R10 write zero keeps", a0, 3);
    wr(2, 1);
    rd(2, a0, a1); chk("R10 clear bit0 only", a0, 2);
    drv(1, 0, 2, 2, 0, 0, 1, 8'hA3);
    idle();
    rd(2, a0, a1); chk("R10 set wins over clear", a0, 2);
    drv(1, 0, 1, 3, 0, 0, 0, 0);
    drv(1, 0, 2, 3, 0, 0, 0, 0);
    idle();
    chk("R11 irq low when clear", int'(irqo[0]), 0);

    wr(0, 32'h091);
    tx(8'h55);
    chk("R3 static replaces tx", int'(txo[0]), 8'h91);
    rx(8'h00);
    chk("R3 static replaces rx", int'(rxo[0]), 8'h91);
    wr(0, 32'h0D2);
    tx(8'hE0);
    chk("R3 static hdr validated", int'(txo[0]), 8'h02);
    chk("R3 static bad method drops", int'(txd[0]), 1);

    drv(1, 0, 0, 32'h100, 1, 8'hE0, 0, 0);
    idle();
    chk("R12 mode write not yet active", int'(txo[0]), 8'h02);
    tx(8'hE0);
    chk("R12 mode write active next", int'(txo[0]), 8'hE0);
    idle();
    chk("R12 vld one cycle", int'(txv[0]), 0);

    for (int h = 0; h < 256; h++) drv(0, 0, 0, 0, 1, h, 1, 255 - h);
    idle();
    for (int h = 0; h < 256; h++) drv(0, 0, 0, 0, h % 2 == 0, h, h % 3 == 0, h);
    idle();
    rd(1, a0, a1);
    rd(2, a0, a1);
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule